// File: doc/BRIEF.md
# CAN FD Data-Phase Bit Timing Generator

This block produces the time-quantum clock enable and the per-bit segment timing used during the fast data phase of a CAN FD frame. A prescaler divides the core clock into time quanta. A sequencer then walks each bit through a one-quantum synchronisation segment, a programmable segment ending at the sample point, and a programmable segment ending at the bit boundary. The block pulses a sample strobe at the sample point and a bit strobe at the bit boundary. It captures the receive line at the sample point so that the value is present on the very next clock edge.

The timing values sit in one 32-bit configuration word. A host writes it through a plain write port, and the write is accepted only while both the configuration-enable input and the init input are high. A falling (recessive-to-dominant) edge on the sampled receive line resynchronises the bit at most once per bit. An edge before the sample point stretches the first segment. An edge after it shortens the second segment. Each correction is limited by the programmed jump width. All pins are plain control and status signals: no data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Configuration word fields (bit positions are the software contract): jump width `sjw` in bits 2:0, post-sample segment `tpost` in bits 7:4, pre-sample segment `tpre` in bits 12:8, prescaler `brp` in bits 20:16, and a stored delay-compensation enable flag in bit 23. Every other bit reads as zero.

Top module: `canfd_dtiming`

## Requirements
- R1: After reset, `rd_data` reads 0x00000A33 (tpre=10, tpost=3, sjw=3, brp=0, flag=0). Bits outside 2:0, 7:4, 12:8, 20:16 and 23 always read 0.
- R2: A write on `wr_en` updates the word only when `cfg_ce` and `cfg_init` are both 1. Otherwise `rd_data` is unchanged.
- R3: A write whose bits 12:8 are zero leaves the stored tpre unchanged and still updates the other fields.
- R4: With `en` high, `tq_tick` pulses once every brp+1 clocks. The first pulse comes brp clocks after the clock in which `en` rose.
- R5: Without resynchronisation, consecutive `bit_stb` pulses are (tpre+tpost+3)*(brp+1) clocks apart.
- R6: `sample_stb` pulses (tpre+2) quanta after a bit starts. It comes before the `bit_stb` that ends the same bit, and never in the same clock.
- R7: `sample_val` takes the sampled receive value on the clock edge that ends the `sample_stb` cycle.
- R8: A falling edge detected in the pre-sample segment at quantum index q (counted from 0) lengthens the bit by min(q+1, sjw+1) quanta.
- R9: A falling edge detected in the post-sample segment at quantum index q shortens the bit by min(tpost-q, sjw+1) quanta.
- R10: A falling edge detected in the sync segment, and any rising edge, leave the bit length unchanged.
- R11: At most one resynchronisation is applied per bit. Later falling edges in the same bit are ignored.
- R12: While `en` is low, `tq_tick`, `sample_stb` and `bit_stb` stay 0 and timing is held. When `en` rises, a new bit starts at the sync segment, so the first `bit_stb` comes (tpre+tpost+3)*(brp+1)-1 clocks after the clock in which `en` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Timing enable; low holds counters at the sync start |
| cfg_ce | input | 1 | Configuration-change enable for the write lock |
| cfg_init | input | 1 | Init request for the write lock |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Current configuration word |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| tq_tick | output | 1 | One-clock pulse per time quantum |
| sample_stb | output | 1 | Pulse in the last clock of the pre-sample segment |
| bit_stb | output | 1 | Pulse in the last clock of the bit |
| sample_val | output | 1 | Receive value captured at the sample point |

## Verification
Fixed and random segment and prescaler settings are applied with a quiet receive line. The measured tick spacing, sample offset and bit period then separate prescaler errors from segment-length errors and from restart-after-enable errors. A single falling edge is placed on every clock of a bit in random trials. This separates stretching (R8), shortening (R9), the sync-segment dead zone (R10) and clamping at the jump width. Directed double-edge and rising-edge patterns separate the once-per-bit rule from edge polarity. Lock and zero-field writes are checked through the read port.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int SJW_W   = 3;
  localparam int T2_W    = 4;
  localparam int T1_W    = 5;
  localparam int BRP_W   = 5;
  localparam int WORD_W  = 32;
  // field placement is the software contract
  localparam int POS_SJW = 0;
  localparam int POS_T2  = 4;
  localparam int POS_T1  = 8;
  localparam int POS_BRP = 16;
  localparam int POS_TDC = 23;
  // quantum counter must hold tpre + max jump
  localparam int Q_W     = T1_W + 2;

  typedef struct packed {
    logic              tdc;
    logic [BRP_W-1:0]  brp;
    logic [T1_W-1:0]   tpre;
    logic [T2_W-1:0]   tpost;
    logic [SJW_W-1:0]  sjw;
  } dtim_cfg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PRE  = 2'd1,
    SEG_POST = 2'd2
  } seg_e;
endpackage

// File: rtl/dtim_regs.sv
module dtim_regs
  import dtim_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = 32'h0000_0A33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              cfg_ce,
  input  logic              cfg_init,
  output dtim_cfg_t         cfg,
  output logic [WORD_W-1:0] rd_data
);
  logic wr_ok;
  logic [T1_W-1:0] tpre_in;

  assign wr_ok   = wr_en && cfg_ce && cfg_init;
  assign tpre_in = wr_data[POS_T1 +: T1_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.sjw   <= RST_WORD[POS_SJW +: SJW_W];
      cfg.tpost <= RST_WORD[POS_T2  +: T2_W];
      cfg.tpre  <= RST_WORD[POS_T1  +: T1_W];
      cfg.brp   <= RST_WORD[POS_BRP +: BRP_W];
      cfg.tdc   <= RST_WORD[POS_TDC];
    end else if (wr_ok) begin
      cfg.sjw   <= wr_data[POS_SJW +: SJW_W];
      cfg.tpost <= wr_data[POS_T2  +: T2_W];
      cfg.brp   <= wr_data[POS_BRP +: BRP_W];
      cfg.tdc   <= wr_data[POS_TDC];
      // a zero pre-sample segment is illegal: keep the old one
      if (tpre_in != '0) cfg.tpre <= tpre_in;
    end
  end

  always_comb begin
    rd_data                      = '0;
    rd_data[POS_SJW +: SJW_W]    = cfg.sjw;
    rd_data[POS_T2  +: T2_W]     = cfg.tpost;
    rd_data[POS_T1  +: T1_W]     = cfg.tpre;
    rd_data[POS_BRP +: BRP_W]    = cfg.brp;
    rd_data[POS_TDC]             = cfg.tdc;
  end
endmodule

// File: rtl/dtim_prescaler.sv
module dtim_prescaler #(
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [BW-1:0] brp,
  output logic          tick
);
  logic [BW-1:0] cnt_q;

  // >= keeps a shrinking divider from running past its limit
  assign tick = en && (cnt_q >= brp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + BW'(1);
  end
endmodule

// File: rtl/dtim_segseq.sv
module dtim_segseq
  import dtim_pkg::*;
#(
  parameter int T1W = T1_W,
  parameter int T2W = T2_W,
  parameter int SW  = SJW_W,
  parameter int QW  = Q_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           tick,
  input  logic [T1W-1:0] tpre,
  input  logic [T2W-1:0] tpost,
  input  logic [SW-1:0]  sjw,
  input  logic           fall,
  output logic           sample_stb,
  output logic           bit_stb
);
  localparam logic [QW-1:0] Q_ONE = QW'(1);

  seg_e          seg_q;
  logic [QW-1:0] qcnt_q;
  logic [QW-1:0] adj_q;
  logic          rs_done_q;

  logic [QW-1:0] pre_x, post_x, jump, qnext;
  logic [QW-1:0] ext_new, rem, shr_new, adj_new, adj_eff, lim_pre, lim_post;
  logic          rs_now, end_pre, end_post;

  always_comb begin
    pre_x   = QW'(tpre);
    post_x  = QW'(tpost);
    jump    = QW'(sjw) + Q_ONE;
    qnext   = qcnt_q + Q_ONE;
    // stretch: phase error is quanta elapsed since the sync segment
    ext_new = (qnext < jump) ? qnext : jump;
    // shorten: never below the quantum now running
    rem     = (qcnt_q < post_x) ? (post_x - qcnt_q) : '0;
    shr_new = (rem < jump) ? rem : jump;
    adj_new = (seg_q == SEG_PRE) ? ext_new : shr_new;
    rs_now  = en && fall && !rs_done_q && (seg_q != SEG_SYNC);
    adj_eff = rs_now ? adj_new : adj_q;
    lim_pre  = pre_x + adj_eff;
    lim_post = (post_x > adj_eff) ? (post_x - adj_eff) : '0;
    end_pre  = tick && (seg_q == SEG_PRE)  && (qcnt_q >= lim_pre);
    end_post = tick && (seg_q == SEG_POST) && (qcnt_q >= lim_post);
  end

  assign sample_stb = end_pre;
  assign bit_stb    = end_post;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      adj_q     <= '0;
      rs_done_q <= 1'b0;
    end else if (!en) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      adj_q     <= '0;
      rs_done_q <= 1'b0;
    end else begin
      if (rs_now) begin
        adj_q     <= adj_new;
        rs_done_q <= 1'b1;
      end
      if (tick) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_q  <= SEG_PRE;
            qcnt_q <= '0;
          end
          SEG_PRE: begin
            if (end_pre) begin
              seg_q  <= SEG_POST;
              qcnt_q <= '0;
              adj_q  <= '0;
            end else begin
              qcnt_q <= qnext;
            end
          end
          SEG_POST: begin
            if (end_post) begin
              seg_q     <= SEG_SYNC;
              qcnt_q    <= '0;
              adj_q     <= '0;
              rs_done_q <= 1'b0;
            end else begin
              qcnt_q <= qnext;
            end
          end
          default: seg_q <= SEG_SYNC;
        endcase
      end
    end
  end
endmodule

// File: rtl/canfd_dtiming.sv
module canfd_dtiming
  import dtim_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = 32'h0000_0A33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              cfg_ce,
  input  logic              cfg_init,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rx_in,
  output logic              tq_tick,
  output logic              sample_stb,
  output logic              bit_stb,
  output logic              sample_val
);
  dtim_cfg_t cfg;
  logic      rx_smp, rx_prev, fall;

  dtim_regs #(.RST_WORD(RST_WORD)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_ce   (cfg_ce),
    .cfg_init (cfg_init),
    .cfg      (cfg),
    .rd_data  (rd_data)
  );

  dtim_prescaler #(.BW(BRP_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .brp   (cfg.brp),
    .tick  (tq_tick)
  );

  // receive sampling and falling-edge detect, recessive at reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_smp  <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_smp  <= rx_in;
      rx_prev <= rx_smp;
    end
  end
  assign fall = rx_prev && !rx_smp;

  dtim_segseq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .tick       (tq_tick),
    .tpre       (cfg.tpre),
    .tpost      (cfg.tpost),
    .sjw        (cfg.sjw),
    .fall       (fall),
    .sample_stb (sample_stb),
    .bit_stb    (bit_stb)
  );

  // zero processing time: value is out on the edge after the sample point
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sample_val <= 1'b1;
    else if (sample_stb) sample_val <= rx_smp;
  end
endmodule

// File: rtl/canfd_dtiming_chk.sv
module canfd_dtiming_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        cfg_ce,
  input logic        cfg_init,
  input logic [31:0] rd_data,
  input logic        tq_tick,
  input logic        sample_stb,
  input logic        bit_stb,
  input logic        sample_val,
  input logic        rx_smp
);
  assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(tq_tick || sample_stb || bit_stb));

  assert_strobe_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || bit_stb) |-> tq_tick);

  assert_strobes_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sample_stb, bit_stb}) <= 1);

  assert_locked_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ce && cfg_init) |=> $stable(rd_data));

  assert_sample_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> (sample_val == $past(rx_smp)));

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 32'hFF60_E008) == 32'h0);
endmodule

bind canfd_dtiming canfd_dtiming_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .cfg_ce     (cfg_ce),
  .cfg_init   (cfg_init),
  .rd_data    (rd_data),
  .tq_tick    (tq_tick),
  .sample_stb (sample_stb),
  .bit_stb    (bit_stb),
  .sample_val (sample_val),
  .rx_smp     (rx_smp)
);

// File: tb/sim_canfd_dtiming.sv
`timescale 1ns/1ps
module sim_canfd_dtiming;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_ce = 1'b0;
  logic        cfg_init = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rx_in = 1'b1;
  logic        tq_tick, sample_stb, bit_stb, sample_val;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  canfd_dtiming u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_ce(cfg_ce), .cfg_init(cfg_init),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rx_in(rx_in),
    .tq_tick(tq_tick), .sample_stb(sample_stb), .bit_stb(bit_stb),
    .sample_val(sample_val)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(int tpre, int tpost, int sjw, int brp);
    return (32'(brp) << 16) | (32'(tpre) << 8) | (32'(tpost) << 4) | 32'(sjw);
  endfunction

  // expected bit length in quanta for one falling edge driven d clocks
  // after the bit_stb cycle (seen by the sequencer one clock later)
  function automatic int exp_len(int tpre, int tpost, int sjw, int d);
    int n, e, q, a;
    n = tpre + tpost + 3;
    e = d + 1;
    if (d < 0 || e < 2) return n;
    if (e <= tpre + 2) begin
      a = e - 1;
      if (a > sjw + 1) a = sjw + 1;
      return n + a;
    end
    q = e - (tpre + 3);
    a = tpost - q;
    if (a > sjw + 1) a = sjw + 1;
    return n - a;
  endfunction

  task automatic wr(input logic [31:0] d, input bit ce, input bit ini);
    @(negedge clk);
    wr_data = d; wr_en = 1'b1; cfg_ce = ce; cfg_init = ini;
    @(negedge clk);
    wr_en = 1'b0; cfg_ce = 1'b0; cfg_init = 1'b0;
    #1;
  endtask

  task automatic wait_bit(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (bit_stb) begin ok = 1'b1; break; end
    end
  endtask

  // R4 R5 R6 R12: timing from enable with a quiet line
  task automatic run_timing(input int tpre, input int tpost, input int sjw, input int brp);
    int t0, t1i, fs, fb, sb, n;
    bit quiet;
    @(negedge clk); en = 1'b0; rx_in = 1'b1;
    wr(mkcfg(tpre, tpost, sjw, brp), 1'b1, 1'b1);
    quiet = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (tq_tick || sample_stb || bit_stb) quiet = 1'b0;
    end
    chk(quiet, "R12 no strobes while disabled", quiet, 1);
    t0 = -1; t1i = -1; fs = -1; fb = -1; sb = -1;
    @(negedge clk); en = 1'b1;
    for (int c = 0; c < 5000; c++) begin
      #1;
      if (tq_tick) begin
        if (t0 < 0) t0 = c; else if (t1i < 0) t1i = c;
      end
      if (sample_stb && fs < 0) fs = c;
      if (bit_stb) begin
        if (fb < 0) fb = c; else if (sb < 0) sb = c;
      end
      if (sb >= 0) break;
      @(negedge clk);
    end
    n = tpre + tpost + 3;
    chk(t0 == brp, "R4 first quantum tick", t0, brp);
    chk(t1i - t0 == brp + 1, "R4 quantum spacing", t1i - t0, brp + 1);
    chk(fs == (tpre + 2) * (brp + 1) - 1, "R6 sample offset", fs, (tpre + 2) * (brp + 1) - 1);
    chk(fb == n * (brp + 1) - 1, "R12 first bit after enable", fb, n * (brp + 1) - 1);
    chk(sb - fb == n * (brp + 1), "R5 bit period", sb - fb, n * (brp + 1));
    @(negedge clk); en = 1'b0;
  endtask

  // resync trial with brp = 0; up to three rx events at clock offsets
  task automatic run_rs(input string req, input int tpre, input int tpost, input int sjw,
                        input bit rx0, input int ta, input bit va, input int tb, input bit vb,
                        input int tc, input bit vc, input int expq);
    bit ok;
    int len;
    @(negedge clk); en = 1'b0; rx_in = rx0;
    wr(mkcfg(tpre, tpost, sjw, 0), 1'b1, 1'b1);
    @(negedge clk); en = 1'b1;
    wait_bit(ok);
    wait_bit(ok);
    len = -1;
    for (int c = 0; c < 200; c++) begin
      if (c == ta) rx_in = va;
      if (c == tb) rx_in = vb;
      if (c == tc) rx_in = vc;
      @(negedge clk); #1;
      if (bit_stb) begin len = c + 1; break; end
    end
    chk(ok && len == expq, req, len, expq);
    @(negedge clk); en = 1'b0; rx_in = 1'b1;
  endtask

  initial begin
    int t1r, t2r, sr, br, dr, n;
    bit ok;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rd_data == 32'h0000_0A33, "R1 reset word", rd_data, 32'h0000_0A33);

    wr(32'h0000_0000, 1'b1, 1'b0);
    chk(rd_data == 32'h0000_0A33, "R2 write with init low ignored", rd_data, 32'h0000_0A33);
    wr(32'h0000_0000, 1'b0, 1'b1);
    chk(rd_data == 32'h0000_0A33, "R2 write with ce low ignored", rd_data, 32'h0000_0A33);
    wr(32'hFFFF_FFFF, 1'b1, 1'b1);
    chk(rd_data == 32'h009F_1FF7, "R1 R2 all-ones write, reserved zero", rd_data, 32'h009F_1FF7);
    wr(32'h0003_0052, 1'b1, 1'b1);
    chk(rd_data == 32'h0003_1F52, "R3 zero tpre keeps old value", rd_data, 32'h0003_1F52);

    // directed timing corners
    run_timing(10, 3, 3, 0);
    run_timing(1, 0, 0, 0);
    run_timing(31, 15, 7, 31);
    run_timing(4, 2, 1, 3);
    for (int k = 0; k < 20; k++) begin
      run_timing($urandom_range(1, 15), $urandom_range(0, 15), $urandom_range(0, 7),
                 $urandom_range(0, 4));
    end

    // R7: capture appears one edge after the sample strobe
    @(negedge clk); en = 1'b0; rx_in = 1'b1;
    wr(mkcfg(10, 3, 3, 0), 1'b1, 1'b1);
    @(negedge clk); en = 1'b1;
    wait_bit(ok); wait_bit(ok);
    rx_in = 1'b0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk); #1;
      if (sample_stb) break;
    end
    chk(sample_val == 1'b1, "R7 value held during sample cycle", sample_val, 1);
    @(negedge clk); #1;
    chk(sample_val == 1'b0, "R7 value updated one edge after sample", sample_val, 0);
    @(negedge clk); en = 1'b0; rx_in = 1'b1;

    // directed resync cases, tpre=8 tpost=6 sjw=1 (nominal 17)
    run_rs("R8 stretch clamped to jump", 8, 6, 1, 1'b1, 5, 1'b0, -1, 1'b0, -1, 1'b0,
           exp_len(8, 6, 1, 5));
    run_rs("R8 stretch by phase error", 8, 6, 7, 1'b1, 2, 1'b0, -1, 1'b0, -1, 1'b0,
           exp_len(8, 6, 7, 2));
    run_rs("R9 shorten clamped to jump", 8, 6, 1, 1'b1, 11, 1'b0, -1, 1'b0, -1, 1'b0,
           exp_len(8, 6, 1, 11));
    run_rs("R9 shorten by remaining", 8, 6, 7, 1'b1, 14, 1'b0, -1, 1'b0, -1, 1'b0,
           exp_len(8, 6, 7, 14));
    run_rs("R10 edge in sync segment", 8, 6, 7, 1'b1, 0, 1'b0, -1, 1'b0, -1, 1'b0, 17);
    run_rs("R10 rising edge ignored", 8, 6, 7, 1'b0, 3, 1'b1, -1, 1'b0, -1, 1'b0, 17);
    run_rs("R11 second fall in same bit ignored", 8, 6, 1, 1'b1, 2, 1'b0, 4, 1'b1, 14, 1'b0,
           19);

    // random single-edge placement
    for (int k = 0; k < 40; k++) begin
      t1r = $urandom_range(1, 10);
      t2r = $urandom_range(0, 10);
      sr  = $urandom_range(0, 7);
      n   = t1r + t2r + 3;
      dr  = $urandom_range(0, n - 1);
      run_rs("R8 R9 R10 random edge position", t1r, t2r, sr, 1'b1, dr, 1'b0, -1, 1'b0, -1,
             1'b0, exp_len(t1r, t2r, sr, dr));
    end
    br = 0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule